// File: doc/BRIEF.md
# Configuration ROM Entry Walker

This block steps through the chain of variable-length entries that sits after the fixed 22-byte header of a device configuration ROM image. The image is held in an external byte buffer. The walker reads that buffer through a synchronous read port. The caller provides the total image size and the highest port index the device has, then pulses `start`.

Each entry opens with a two-byte header. The first byte is the entry length. The second byte packs together the index, a port-disabled flag and the entry type. The walker sorts each entry into one of two kinds, generic or port. For a port entry that is enabled, it also fetches two more bytes to get the link and dual-link fields.

Every entry that is kept produces one record, offered on a valid/ready handshake. The record also gives the payload start and the payload length, so a downstream agent can fetch names or descriptors on its own. At the end of the walk, a one-cycle `done` pulse reports either success or the first error found.

Top module: `rom_entry_walker`

## Requirements
- R1: While `rst` is high, `rd_en`, `rec_valid`, `done` and `busy` are all low.
- R2: The walk begins at byte offset 22 and finishes with `done` and code 0 (none) as soon as the position is at or beyond `total_size`. A size of 22 or less therefore gives no records.
- R3: In each entry, byte 0 is the length. In byte 1, bits 5..0 are the index, bit 7 is the type (0 generic, 1 port) and bit 6 is the disabled flag. Bit 6 is reported only for port entries and reads as 0 for generic ones.
- R4: The walk stops with code 1 (overrun) and gives no record for the failing entry in any of these cases: the position plus 1 equals the size, the length is zero, or the position plus the length is greater than the size.
- R5: After an entry, the position moves on by exactly that entry's length. Each entry that is kept gives exactly one record, in list order.
- R6: A port entry whose index is greater than `max_port` gives no record and raises no error, whatever its length, and the walk goes on. An index equal to `max_port` is kept.
- R7: A disabled port entry gives a record with `rec_disabled`=1 and with link, dual-valid and dual-port all 0. No length rule applies to it.
- R8: An enabled port entry that is in range and whose length is not 8 stops the walk with code 2 (port length).
- R9: For a decoded port entry, `rec_link` is bit 4 of entry byte 2, `rec_dual_valid` is bit 7 of entry byte 2, and `rec_dual_port` is bits 5..0 of entry byte 3.
- R10: `rec_class` is 1 for generic index 1 (vendor name), 2 for generic index 2 (device name), 3 for generic index 9 (product descriptor), and 0 for every other case, ports included. `rec_pay_start` is the position plus 2, and `rec_pay_len` is the length minus 2.
- R11: While `rec_valid` is high and `rec_ready` is low, the record stays unchanged and the walk does not move on.
- R12: The read port returns `rd_data` one cycle after `rd_en`. No read is ever issued at an address at or beyond `total_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| total_size | input | 16 | Image size in bytes (data length + 13) |
| max_port | input | 6 | Highest valid port index |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | 16 | Buffer byte address |
| rd_data | input | 8 | Buffer byte, one cycle after request |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts record |
| rec_is_port | output | 1 | Entry type: 1 port, 0 generic |
| rec_index | output | 6 | Entry index |
| rec_disabled | output | 1 | Port entry marked disabled |
| rec_link | output | 1 | Port link number |
| rec_dual_valid | output | 1 | Port has a dual-link partner |
| rec_dual_port | output | 6 | Dual-link partner port number |
| rec_class | output | 2 | Generic payload class |
| rec_pay_start | output | 16 | Byte address of entry payload |
| rec_pay_len | output | 8 | Payload length in bytes |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_err | output | 2 | End code: 0 none, 1 overrun, 2 port length |

## Verification
Three situations are hard to reach from the ports. The first is the overrun case where exactly one byte is left, which must be caught before that byte's neighbour is read. The second is a port entry that is skipped for range even though its length is illegal. The third is a port entry whose index equals `max_port`. The bench builds each ROM image byte by byte so that the entry chain lands on one of these corners at a chosen offset. While it does so, it pushes the records the requirements predict into a queue. A monitor then compares the records against the queue while `rec_ready` follows a stalling pattern, so every record is also seen held across a back-pressure cycle.

// File: rtl/rew_pkg.sv
package rew_pkg;
    localparam int AW           = 16;
    localparam int BYTE_W       = 8;
    localparam int IDX_W        = 6;
    localparam int HDR_LEN      = 22;
    localparam int ENT_HDR_LEN  = 2;
    localparam int PORT_ENT_LEN = 8;

    typedef enum logic {KIND_GENERIC = 1'b0, KIND_PORT = 1'b1} entry_kind_e;

    typedef enum logic [1:0] {
        GCLS_OTHER   = 2'd0,
        GCLS_VENDOR  = 2'd1,
        GCLS_DEVICE  = 2'd2,
        GCLS_PRODUCT = 2'd3
    } gen_class_e;

    typedef enum logic [1:0] {
        WERR_NONE     = 2'd0,
        WERR_OVERRUN  = 2'd1,
        WERR_PORT_LEN = 2'd2
    } walk_err_e;

    typedef enum logic [2:0] {
        VD_OVERRUN, VD_SKIP, VD_BADLEN, VD_EMIT, VD_BODY
    } verdict_e;

    typedef struct packed {
        entry_kind_e       kind;
        logic [IDX_W-1:0]  index;
        logic              disabled;
        logic              link;
        logic              dual_valid;
        logic [IDX_W-1:0]  dual_port;
        gen_class_e        gclass;
        logic [AW-1:0]     pay_start;
        logic [BYTE_W-1:0] pay_len;
    } entry_rec_t;

    function automatic gen_class_e class_of(logic [IDX_W-1:0] idx);
        case (idx)
            6'd1:    return GCLS_VENDOR;
            6'd2:    return GCLS_DEVICE;
            6'd9:    return GCLS_PRODUCT;
            default: return GCLS_OTHER;
        endcase
    endfunction

    function automatic entry_rec_t build_rec(
        logic [BYTE_W-1:0] len, logic [BYTE_W-1:0] hdr, logic [AW-1:0] pos,
        logic link, logic dual_valid, logic [IDX_W-1:0] dual_port);
        entry_rec_t r;
        r.kind       = entry_kind_e'(hdr[7]);
        r.index      = hdr[IDX_W-1:0];
        r.disabled   = hdr[7] & hdr[6];
        r.link       = link;
        r.dual_valid = dual_valid;
        r.dual_port  = dual_port;
        r.gclass     = hdr[7] ? GCLS_OTHER : class_of(hdr[IDX_W-1:0]);
        r.pay_start  = pos + AW'(ENT_HDR_LEN);
        r.pay_len    = len - BYTE_W'(ENT_HDR_LEN);
        return r;
    endfunction
endpackage

// File: rtl/rew_decode.sv
module rew_decode
    import rew_pkg::*;
#(
    parameter int PORT_LEN = PORT_ENT_LEN
) (
    input  logic [AW-1:0]     pos,
    input  logic [AW-1:0]     tot,
    input  logic [BYTE_W-1:0] len,
    input  logic [BYTE_W-1:0] hdr,
    input  logic [IDX_W-1:0]  mport,
    output verdict_e          verdict
);
    logic [AW:0] end_sum;

    always_comb begin
        end_sum = {1'b0, pos} + (AW+1)'(len);
        if (len == '0 || end_sum > {1'b0, tot})
            verdict = VD_OVERRUN;
        else if (!hdr[7])
            verdict = VD_EMIT;
        else if (hdr[IDX_W-1:0] > mport)
            verdict = VD_SKIP;
        else if (hdr[6])
            verdict = VD_EMIT;
        else if (len != BYTE_W'(PORT_LEN))
            verdict = VD_BADLEN;
        else
            verdict = VD_BODY;
    end
endmodule

// File: rtl/rew_seq.sv
module rew_seq
    import rew_pkg::*;
#(
    parameter int START_POS = HDR_LEN,
    parameter int PORT_LEN  = PORT_ENT_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     total_size,
    input  logic [IDX_W-1:0]  max_port,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  verdict_e          verdict,
    output logic [AW-1:0]     pos,
    output logic [AW-1:0]     tot,
    output logic [BYTE_W-1:0] len_q,
    output logic [BYTE_W-1:0] hdr_q,
    output logic [IDX_W-1:0]  mport,
    output logic              rec_valid,
    input  logic              rec_ready,
    output entry_rec_t        rec_q,
    output logic              busy,
    output logic              done,
    output walk_err_e         done_err
);
    typedef enum logic [3:0] {
        S_IDLE, S_NEXT, S_H0, S_H1, S_CHK, S_B0, S_B1, S_EMIT, S_FIN
    } walk_state_e;

    walk_state_e st;
    logic [1:0]  b2_q;
    walk_err_e   err_q;
    logic [AW:0] pos_plus1;
    logic [AW-1:0] pos_adv;

    assign pos_plus1 = {1'b0, pos} + (AW+1)'(1);
    assign pos_adv   = pos + AW'(len_q);
    assign rec_valid = (st == S_EMIT);
    assign done      = (st == S_FIN);
    assign busy      = (st != S_IDLE);
    assign done_err  = err_q;

    always_comb begin
        rd_en   = 1'b0;
        rd_addr = pos;
        case (st)
            S_NEXT: begin
                rd_en = (pos < tot) && (pos_plus1 != {1'b0, tot});
            end
            S_H0: begin
                rd_en   = 1'b1;
                rd_addr = pos + AW'(1);
            end
            S_CHK: begin
                rd_en   = (verdict == VD_BODY);
                rd_addr = pos + AW'(2);
            end
            S_B0: begin
                rd_en   = 1'b1;
                rd_addr = pos + AW'(3);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            pos   <= '0;
            tot   <= '0;
            mport <= '0;
            len_q <= '0;
            hdr_q <= '0;
            b2_q  <= '0;
            rec_q <= '0;
            err_q <= WERR_NONE;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    pos   <= AW'(START_POS);
                    tot   <= total_size;
                    mport <= max_port;
                    err_q <= WERR_NONE;
                    st    <= S_NEXT;
                end
                S_NEXT: begin
                    if (pos >= tot)
                        st <= S_FIN;
                    else if (pos_plus1 == {1'b0, tot}) begin
                        err_q <= WERR_OVERRUN;
                        st    <= S_FIN;
                    end else
                        st <= S_H0;
                end
                S_H0: begin
                    len_q <= rd_data;
                    st    <= S_H1;
                end
                S_H1: begin
                    hdr_q <= rd_data;
                    st    <= S_CHK;
                end
                S_CHK: begin
                    case (verdict)
                        VD_OVERRUN: begin
                            err_q <= WERR_OVERRUN;
                            st    <= S_FIN;
                        end
                        VD_BADLEN: begin
                            err_q <= WERR_PORT_LEN;
                            st    <= S_FIN;
                        end
                        VD_SKIP: begin
                            pos <= pos_adv;
                            st  <= S_NEXT;
                        end
                        VD_EMIT: begin
                            rec_q <= build_rec(len_q, hdr_q, pos, 1'b0, 1'b0, '0);
                            st    <= S_EMIT;
                        end
                        default: st <= S_B0;
                    endcase
                end
                S_B0: begin
                    b2_q <= {rd_data[7], rd_data[4]};
                    st   <= S_B1;
                end
                S_B1: begin
                    rec_q <= build_rec(len_q, hdr_q, pos, b2_q[0], b2_q[1],
                                       rd_data[IDX_W-1:0]);
                    st    <= S_EMIT;
                end
                S_EMIT: if (rec_ready) begin
                    pos <= pos_adv;
                    st  <= S_NEXT;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assert_rec_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_q)));

    assert_rd_bound_R12: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr < tot));

    assert_port_range_R6: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_q.kind == KIND_PORT) |-> (rec_q.index <= mport));

    assert_port_len_R8: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_q.kind == KIND_PORT && !rec_q.disabled)
        |-> (rec_q.pay_len == BYTE_W'(PORT_LEN - ENT_HDR_LEN)));

    assert_overrun_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (done && err_q != WERR_NONE) |=> !busy);
endmodule

// File: rtl/rom_entry_walker.sv
module rom_entry_walker
    import rew_pkg::*;
#(
    parameter int FIRST_ENTRY = HDR_LEN,
    parameter int PORT_LEN    = PORT_ENT_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     total_size,
    input  logic [IDX_W-1:0]  max_port,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic              rec_is_port,
    output logic [IDX_W-1:0]  rec_index,
    output logic              rec_disabled,
    output logic              rec_link,
    output logic              rec_dual_valid,
    output logic [IDX_W-1:0]  rec_dual_port,
    output logic [1:0]        rec_class,
    output logic [AW-1:0]     rec_pay_start,
    output logic [BYTE_W-1:0] rec_pay_len,
    output logic              busy,
    output logic              done,
    output logic [1:0]        done_err
);
    logic [AW-1:0]     pos, tot;
    logic [BYTE_W-1:0] len_q, hdr_q;
    logic [IDX_W-1:0]  mport;
    verdict_e          verdict;
    entry_rec_t        rec;
    walk_err_e         err;

    rew_decode #(.PORT_LEN(PORT_LEN)) u_dec (
        .pos(pos), .tot(tot), .len(len_q), .hdr(hdr_q), .mport(mport),
        .verdict(verdict)
    );

    rew_seq #(.START_POS(FIRST_ENTRY), .PORT_LEN(PORT_LEN)) u_seq (
        .clk(clk), .rst(rst), .start(start), .total_size(total_size),
        .max_port(max_port), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .verdict(verdict), .pos(pos), .tot(tot),
        .len_q(len_q), .hdr_q(hdr_q), .mport(mport), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_q(rec), .busy(busy), .done(done),
        .done_err(err)
    );

    assign rec_is_port    = rec.kind;
    assign rec_index      = rec.index;
    assign rec_disabled   = rec.disabled;
    assign rec_link       = rec.link;
    assign rec_dual_valid = rec.dual_valid;
    assign rec_dual_port  = rec.dual_port;
    assign rec_class      = rec.gclass;
    assign rec_pay_start  = rec.pay_start;
    assign rec_pay_len    = rec.pay_len;
    assign done_err       = err;
endmodule

// File: tb/rom_entry_walker_bench.sv
module rom_entry_walker_bench;
    import rew_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst = 1'b1, start = 1'b0, rec_ready = 1'b0;
    logic [15:0] total_size = '0;
    logic [5:0]  max_port = '0;
    logic        rd_en, rec_valid, busy, done;
    logic [15:0] rd_addr, rec_pay_start;
    logic [7:0]  rd_data = '0, rec_pay_len;
    logic        rec_is_port, rec_disabled, rec_link, rec_dual_valid;
    logic [5:0]  rec_index, rec_dual_port;
    logic [1:0]  rec_class, done_err;

    rom_entry_walker u_rom_entry_walker (
        .clk(clk), .rst(rst), .start(start), .total_size(total_size),
        .max_port(max_port), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_is_port(rec_is_port), .rec_index(rec_index),
        .rec_disabled(rec_disabled), .rec_link(rec_link),
        .rec_dual_valid(rec_dual_valid), .rec_dual_port(rec_dual_port),
        .rec_class(rec_class), .rec_pay_start(rec_pay_start),
        .rec_pay_len(rec_pay_len), .busy(busy), .done(done),
        .done_err(done_err)
    );

    logic [7:0] mem [0:255];
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

    int n_checks = 0, n_fail = 0, cyc = 0, wpos = 22;
    entry_rec_t exp_q[$];
    bit done_seen = 0, stall_prev = 0;
    logic [1:0] got_err = '0;
    entry_rec_t saved;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic entry_rec_t cur_rec();
        entry_rec_t r;
        r.kind = entry_kind_e'(rec_is_port);
        r.index = rec_index;
        r.disabled = rec_disabled;
        r.link = rec_link;
        r.dual_valid = rec_dual_valid;
        r.dual_port = rec_dual_port;
        r.gclass = gen_class_e'(rec_class);
        r.pay_start = rec_pay_start;
        r.pay_len = rec_pay_len;
        return r;
    endfunction

    task automatic cmp_rec(entry_rec_t g, entry_rec_t e);
        chk("R3", "type", 32'(g.kind), 32'(e.kind));
        chk("R3", "index", 32'(g.index), 32'(e.index));
        chk("R7", "disabled", 32'(g.disabled), 32'(e.disabled));
        chk("R9", "link", 32'(g.link), 32'(e.link));
        chk("R9", "dual valid", 32'(g.dual_valid), 32'(e.dual_valid));
        chk("R9", "dual port", 32'(g.dual_port), 32'(e.dual_port));
        chk("R10", "class", 32'(g.gclass), 32'(e.gclass));
        chk("R10", "payload start", 32'(g.pay_start), 32'(e.pay_start));
        chk("R10", "payload length", 32'(g.pay_len), 32'(e.pay_len));
    endtask

    // monitor: scoreboard pop, stall hold, read bounds, end code
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (stall_prev) begin
                chk("R11", "valid held", 32'(rec_valid), 32'd1);
                chk("R11", "record held", 32'(cur_rec() == saved), 32'd1);
            end
            rec_ready = (cyc % 3) != 0;
            if (rec_valid && rec_ready) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R5 unexpected record: actual 1 expected 0");
                end else
                    cmp_rec(cur_rec(), exp_q.pop_front());
            end
            stall_prev = rec_valid && !rec_ready;
            saved = cur_rec();
            if (rd_en) chk("R12", "read address in image", 32'(rd_addr < total_size), 32'd1);
            if (done) begin
                done_seen = 1;
                got_err = done_err;
            end
        end
    end

    function automatic gen_class_e exp_class(int idx);
        if (idx == 1) return GCLS_VENDOR;
        if (idx == 2) return GCLS_DEVICE;
        if (idx == 9) return GCLS_PRODUCT;
        return GCLS_OTHER;
    endfunction

    task automatic clear_img();
        for (int i = 0; i < 256; i++) mem[i] = 8'hA5;
        wpos = 22;
    endtask

    task automatic add_gen(int idx, int len, bit b6);
        entry_rec_t e;
        mem[wpos] = 8'(len);
        mem[wpos+1] = {1'b0, b6, 6'(idx)};
        for (int k = 2; k < len; k++) mem[wpos+k] = 8'(k + 8'h30);
        e = '0;
        e.kind = KIND_GENERIC; e.index = 6'(idx); e.gclass = exp_class(idx);
        e.pay_start = 16'(wpos + 2); e.pay_len = 8'(len - 2);
        exp_q.push_back(e);
        wpos += len;
    endtask

    task automatic add_port(int idx, int len, bit dis, logic [7:0] b2, logic [7:0] b3, bit keep);
        entry_rec_t e;
        mem[wpos] = 8'(len);
        mem[wpos+1] = {1'b1, dis, 6'(idx)};
        for (int k = 2; k < len; k++) mem[wpos+k] = 8'hFF;
        if (len > 2) mem[wpos+2] = b2;
        if (len > 3) mem[wpos+3] = b3;
        if (keep) begin
            e = '0;
            e.kind = KIND_PORT; e.index = 6'(idx); e.disabled = dis;
            if (!dis) begin
                e.link = b2[4]; e.dual_valid = b2[7]; e.dual_port = b3[5:0];
            end
            e.gclass = GCLS_OTHER;
            e.pay_start = 16'(wpos + 2); e.pay_len = 8'(len - 2);
            exp_q.push_back(e);
        end
        wpos += len;
    endtask

    task automatic run_case(int total, int mport, logic [1:0] exp_err, string req);
        total_size = 16'(total);
        max_port = 6'(mport);
        done_seen = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int t = 0; t < 4000 && !done_seen; t++) @(negedge clk);
        if (!done_seen) begin
            n_checks++; n_fail++;
            $display("FAIL %s watchdog: done actual 0 expected 1", req);
        end else
            chk(req, "end code", 32'(got_err), 32'(exp_err));
        chk("R5", "records left unmatched", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        clear_img();
        repeat (3) @(negedge clk);
        chk("R1", "rd_en in reset", 32'(rd_en), 32'd0);
        chk("R1", "rec_valid in reset", 32'(rec_valid), 32'd0);
        chk("R1", "done in reset", 32'(done), 32'd0);
        chk("R1", "busy in reset", 32'(busy), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2: empty list, and a size below the header
        clear_img(); run_case(22, 7, 2'd0, "R2");
        clear_img(); run_case(10, 7, 2'd0, "R2");

        // R3 R5 R6 R7 R9 R10: mixed list ending exactly at the size
        clear_img();
        add_gen(1, 6, 1'b0);
        add_gen(2, 5, 1'b0);
        add_port(40, 5, 1'b0, 8'h90, 8'h01, 1'b0);        // R6 skipped, odd length
        add_gen(9, 4, 1'b1);                               // R3 bit 6 ignored on generic
        add_port(3, 8, 1'b0, 8'h90, 8'hC4, 1'b1);          // R9 link 1, dual 4
        add_port(2, 3, 1'b1, 8'h90, 8'h00, 1'b1);          // R7 disabled, length 3
        add_gen(5, 2, 1'b0);                               // R10 empty payload
        add_port(7, 8, 1'b0, 8'h6F, 8'hFF, 1'b1);          // R6 index equal to max
        run_case(wpos, 7, 2'd0, "R5");

        // R4: zero length
        clear_img(); add_gen(1, 4, 1'b0);
        mem[wpos] = 8'd0; mem[wpos+1] = 8'h01;
        run_case(wpos + 4, 7, 2'd1, "R4");

        // R4: entry runs past the size
        clear_img(); add_gen(2, 3, 1'b0);
        mem[wpos] = 8'd10; mem[wpos+1] = 8'h01;
        run_case(wpos + 6, 7, 2'd1, "R4");

        // R4: one stray byte left
        clear_img(); add_gen(9, 4, 1'b0);
        run_case(wpos + 1, 7, 2'd1, "R4");

        // R8: enabled in-range port with length 7
        clear_img(); add_gen(3, 3, 1'b0);
        add_port(1, 7, 1'b0, 8'h10, 8'h02, 1'b0);
        run_case(wpos, 7, 2'd2, "R8");

        // R6: out-of-range port skipped, boundary port kept
        clear_img();
        add_port(5, 6, 1'b0, 8'h90, 8'h03, 1'b0);
        add_port(4, 8, 1'b0, 8'h10, 8'h02, 1'b1);
        run_case(wpos, 4, 2'd0, "R6");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule